// File: doc/BRIEF.md
# DVP RGB565 Pixel Capture

This block runs on the camera's pixel clock and turns the sensor's byte-wide parallel video stream into 16-bit RGB565 pixels. The sensor delivers one byte per pixel clock while its line-qualify input is high. Two consecutive qualified bytes form one pixel: the first carries red and the upper green bits, the second carries the lower green bits and blue. The block emits the assembled pixel with a one-clock strobe. It also forwards registered copies of the frame-sync and line-qualify signals, so that downstream packing logic can find frame and line boundaries.

The block is held idle, with every output low, until the sensor-configuration-done input is high, in addition to the system reset. After configuration it lets a fixed number of frames go by while exposure and clocks settle, counting frame starts on rising edges of the frame-sync input. Only then does it pass out pixels. The byte phase is cleared whenever the line-qualify input is low, so every line starts on a high byte, even when the previous line ended on an odd byte.

Top module: `dvp_rgb565_capture`

## Requirements
- R1: After the asynchronous reset all outputs are 0.
- R2: While `cfg_done` is low, all outputs are 0 whatever the sensor inputs do. The settling-frame count restarts from zero, and so do the byte phase and the pixel register.
- R3: After `cfg_done` goes high, rising edges of `cam_vsync` are counted. `pix_valid` and `line_valid` stay low until FRAME_SKIP (default 10) frames have passed. The frame that begins with rise number FRAME_SKIP+1 is the first to produce pixels.
- R4: A pixel is `{first byte, second byte}`: the first qualified byte of a pair goes to `pix_data[15:8]` and the second goes to `pix_data[7:0]`.
- R5: `pix_valid` is high for exactly one clock per byte pair, on the second byte of the pair and never on the first. It is never high on two consecutive clocks.
- R6: The byte phase clears whenever `cam_href` is low. An odd trailing byte of a line is dropped, and the next line starts again with a high byte.
- R7: The outputs are two register stages from the pins. Input values sampled at clock edge k appear on the outputs after edge k+1.
- R8: `line_valid` follows `cam_href` with the latency of R7 and is gated by the settling count of R3. `frame_sync` follows `cam_vsync` with the same latency and is not gated by the settling count.
- R9: `pix_data` holds its last value on every clock on which `pix_valid` is low.
- R10: A line of 1280 qualified bytes yields exactly 640 pixel strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_done | input | 1 | Sensor configuration complete; low holds the block idle |
| cam_vsync | input | 1 | Frame sync from the sensor; a rising edge starts a frame |
| cam_href | input | 1 | Line qualify from the sensor; bytes are valid while high |
| cam_byte | input | 8 | Sensor data byte |
| frame_sync | output | 1 | Registered frame sync |
| line_valid | output | 1 | Registered line qualify, gated until settling completes |
| pix_valid | output | 1 | One-clock strobe marking a new pixel on `pix_data` |
| pix_data | output | 16 | Assembled RGB565 pixel |

## Verification
The byte pairing is driven with several line shapes, and each one separates a different fault. A two-byte line with distinct bytes shows whether the halves are swapped and whether the latency is right. A full 1280-byte line catches a phase that slips or strobes too often. An odd-length line followed after one idle clock by a short line shows whether the phase really clears on a low qualify. Runs of short frames before and after a mid-line drop of `cfg_done` test the settling count. They show whether the count is off by one frame, whether it restarts, and whether anything leaks out while the block is held idle.

// File: rtl/dvp_rgb565_capture.sv
`timescale 1ns/1ps
module dvp_rgb565_capture #(
  parameter int FRAME_SKIP = 10
) (
  input  logic        pclk,
  input  logic        rst_n,
  input  logic        cfg_done,
  input  logic        cam_vsync,
  input  logic        cam_href,
  input  logic [7:0]  cam_byte,
  output logic        frame_sync,
  output logic        line_valid,
  output logic        pix_valid,
  output logic [15:0] pix_data
);
  localparam int CNT_W = $clog2(FRAME_SKIP + 2);
  localparam logic [CNT_W-1:0] ARM_AT = CNT_W'(FRAME_SKIP + 1);

  logic             vs_q, vs_q2, hr_q, phase;
  logic [7:0]       byte_q, hi_q;
  logic [CNT_W-1:0] rise_cnt;
  logic             vs_rise, armed, pair_end;

  assign vs_rise  = vs_q & ~vs_q2;
  assign armed    = (rise_cnt == ARM_AT);
  assign pair_end = hr_q & phase;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q <= 1'b0; vs_q2 <= 1'b0; hr_q <= 1'b0; byte_q <= '0;
      phase <= 1'b0; hi_q <= '0; rise_cnt <= '0;
      frame_sync <= 1'b0; line_valid <= 1'b0; pix_valid <= 1'b0; pix_data <= '0;
    end else if (!cfg_done) begin
      vs_q <= 1'b0; vs_q2 <= 1'b0; hr_q <= 1'b0; byte_q <= '0;
      phase <= 1'b0; hi_q <= '0; rise_cnt <= '0;
      frame_sync <= 1'b0; line_valid <= 1'b0; pix_valid <= 1'b0; pix_data <= '0;
    end else begin
      vs_q   <= cam_vsync;
      vs_q2  <= vs_q;
      hr_q   <= cam_href;
      byte_q <= cam_byte;
      if (vs_rise && !armed) rise_cnt <= rise_cnt + CNT_W'(1);
      frame_sync <= vs_q;
      line_valid <= hr_q & armed;
      pix_valid  <= pair_end & armed;
      phase      <= hr_q & ~phase;
      if (hr_q && !phase) hi_q <= byte_q;
      if (pair_end && armed) pix_data <= {hi_q, byte_q};
    end
  end

  // R2
  idle_outputs_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    !cfg_done |=> (!pix_valid && !line_valid && !frame_sync));

  // R5
  single_strobe_chk: assert property (@(posedge pclk) disable iff (!rst_n || !cfg_done)
    pix_valid |=> !pix_valid);

  // R6
  pair_in_line_chk: assert property (@(posedge pclk) disable iff (!rst_n || !cfg_done)
    pix_valid |-> ($past(cam_href, 2) && $past(cam_href, 3)));

  // R8
  line_follows_href_chk: assert property (@(posedge pclk) disable iff (!rst_n || !cfg_done)
    line_valid |-> $past(cam_href, 2));

  // R3
  strobe_in_line_chk: assert property (@(posedge pclk) disable iff (!rst_n || !cfg_done)
    pix_valid |-> line_valid);

  // R9
  data_hold_chk: assert property (@(posedge pclk) disable iff (!rst_n || !cfg_done)
    !pix_valid |-> $stable(pix_data));
endmodule

// File: tb/test_dvp_rgb565_capture.sv
`timescale 1ns/1ps
module test_dvp_rgb565_capture;
  localparam int SKIP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cfg_done = 1'b0, cam_vsync = 1'b0, cam_href = 1'b0;
  logic [7:0] cam_byte = '0;
  logic frame_sync, line_valid, pix_valid;
  logic [15:0] pix_data;

  always #4 clk = ~clk;

  dvp_rgb565_capture #(.FRAME_SKIP(SKIP)) i_dvp_rgb565_capture (
    .pclk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cam_vsync(cam_vsync),
    .cam_href(cam_href), .cam_byte(cam_byte), .frame_sync(frame_sync),
    .line_valid(line_valid), .pix_valid(pix_valid), .pix_data(pix_data));

  int vectors = 0, miscompares = 0;
  int pv_seen = 0, lv_seen = 0, fs_seen = 0;
  bit chk_on = 0, done = 0, cfg_want = 0;
  logic s_fs, s_lv, s_pv;
  logic [15:0] s_data;

  // reference model state
  int m_rises = 0;
  bit m_prev = 0, m_odd = 0;
  logic [7:0] m_hi = '0;
  logic [15:0] m_data = '0;
  logic e1_fs = 0, e1_lv = 0, e1_pv = 0, e2_fs = 0, e2_lv = 0, e2_pv = 0;
  logic [15:0] e1_d = '0, e2_d = '0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic h, input logic [7:0] d);
    logic n_fs, n_lv, n_pv;
    logic [15:0] n_d;
    bit en;
    @(negedge clk);
    s_fs = frame_sync; s_lv = line_valid; s_pv = pix_valid; s_data = pix_data;
    if (chk_on) begin
      chk("R8 frame_sync", s_fs, e2_fs);
      chk("R8 line_valid", s_lv, e2_lv);
      chk("R5 R7 pix_valid", s_pv, e2_pv);
      chk("R4 R9 pix_data", s_data, e2_d);
    end
    if (s_pv) pv_seen++;
    if (s_lv) lv_seen++;
    if (s_fs) fs_seen++;
    cam_vsync = v; cam_href = h; cam_byte = d; cfg_done = cfg_want;
    n_fs = 0; n_lv = 0; n_pv = 0;
    if (!cfg_want) begin
      m_rises = 0; m_prev = 0; m_odd = 0; m_data = '0;
      e1_fs = 0; e1_lv = 0; e1_pv = 0; e1_d = '0;
    end else begin
      en = (m_rises > SKIP);
      if (v && !m_prev && m_rises <= SKIP) m_rises++;
      m_prev = v;
      n_fs = v;
      n_lv = h && en;
      if (h) begin
        if (!m_odd) begin m_hi = d; m_odd = 1; end
        else begin
          m_odd = 0;
          if (en) begin n_pv = 1; m_data = {m_hi, d}; end
        end
      end else m_odd = 0;
    end
    n_d = m_data;
    e2_fs = e1_fs; e2_lv = e1_lv; e2_pv = e1_pv; e2_d = e1_d;
    e1_fs = n_fs; e1_lv = n_lv; e1_pv = n_pv; e1_d = n_d;
  endtask

  task automatic line(input int nbytes, input int seed);
    for (int b = 0; b < nbytes; b++) step(1'b0, 1'b1, 8'(seed + b * 7));
    step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic frame(input int lines, input int nbytes, input int seed);
    repeat (3) step(1'b1, 1'b0, 8'h00);
    repeat (2) step(1'b0, 1'b0, 8'h00);
    for (int l = 0; l < lines; l++) begin
      line(nbytes, seed + l * 13);
      step(1'b0, 1'b0, 8'h00);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step(1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00);
    chk("R1 frame_sync reset", s_fs, 0);
    chk("R1 line_valid reset", s_lv, 0);
    chk("R1 pix_valid reset", s_pv, 0);
    chk("R1 pix_data reset", s_data, 0);
    chk_on = 1;

    // R2: activity while unconfigured
    pv_seen = 0; lv_seen = 0; fs_seen = 0;
    frame(2, 6, 8'h40);
    frame(2, 6, 8'h50);
    chk("R2 no strobes while unconfigured", pv_seen, 0);
    chk("R2 no line_valid while unconfigured", lv_seen, 0);
    chk("R2 no frame_sync while unconfigured", fs_seen, 0);

    // R3: settling frames
    cfg_want = 1;
    pv_seen = 0; lv_seen = 0; fs_seen = 0;
    for (int f = 0; f < SKIP; f++) frame(2, 6, f * 5);
    chk("R3 no strobes during settling", pv_seen, 0);
    chk("R3 no line_valid during settling", lv_seen, 0);
    chk("R8 frame_sync passes during settling", fs_seen, 3 * SKIP);

    // R4 R7: first frame with output
    repeat (3) step(1'b1, 1'b0, 8'h00);
    repeat (3) step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'hA5);
    step(1'b0, 1'b1, 8'h3C);
    step(1'b0, 1'b0, 8'h00);
    chk("R7 no early strobe", s_pv, 0);
    step(1'b0, 1'b0, 8'h00);
    chk("R7 strobe after two stages", s_pv, 1);
    chk("R4 high byte first", s_data, 16'hA53C);
    step(1'b0, 1'b0, 8'h00);
    chk("R5 strobe lasts one clock", s_pv, 0);

    // R10: full-width line
    pv_seen = 0; lv_seen = 0;
    line(1280, 8'h11);
    repeat (3) step(1'b0, 1'b0, 8'h00);
    chk("R10 strobes per 1280-byte line", pv_seen, 640);
    chk("R8 line_valid length", lv_seen, 1280);

    // R6: odd line, one idle clock, short line
    pv_seen = 0;
    step(1'b0, 1'b1, 8'h11); step(1'b0, 1'b1, 8'h22); step(1'b0, 1'b1, 8'h33);
    step(1'b0, 1'b1, 8'h44); step(1'b0, 1'b1, 8'h55);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b1, 8'h12); step(1'b0, 1'b1, 8'h34);
    repeat (3) step(1'b0, 1'b0, 8'h00);
    chk("R6 pairs from odd line plus short line", pv_seen, 3);
    chk("R6 next line starts on high byte", s_data, 16'h1234);
    repeat (5) step(1'b0, 1'b0, 8'hFF);
    chk("R9 data held while idle", s_data, 16'h1234);

    // R2 R3: drop configuration mid line, settling restarts
    step(1'b0, 1'b1, 8'h01); step(1'b0, 1'b1, 8'h02);
    cfg_want = 0;
    step(1'b0, 1'b1, 8'h03); step(1'b0, 1'b1, 8'h04);
    step(1'b0, 1'b1, 8'h05);
    chk("R2 outputs cleared when unconfigured", s_data, 0);
    step(1'b0, 1'b0, 8'h00);
    cfg_want = 1;
    pv_seen = 0;
    for (int f = 0; f < SKIP; f++) frame(1, 8, f * 3);
    chk("R3 settling restarts after reconfiguration", pv_seen, 0);
    frame(1, 8, 8'h70);
    repeat (2) step(1'b0, 1'b0, 8'h00);
    chk("R3 output resumes after settling", pv_seen, 4);

    done = 1;
    summary();
    $finish;
  end
endmodule